// File: doc/BRIEF.md
# Power-Good and On/Off Sequencer

This block sequences a supply's main converter from a power-on request and decides when the supply may report power-good. The active-low request input is filtered by a tick-based debouncer before it has any effect. Once the filtered request asks for power, the chip supply is valid and the AC sense qualifier reports good input, the main converter is enabled. Power-good follows after every monitored rail has stayed valid for a programmable qualification time.

Turn-off is asymmetric. When the filtered request goes to the off level, power-good falls in that same cycle, but the main converter stays enabled for a short off delay before it is shut down. If the request returns during that delay, the shutdown is abandoned and power-good qualification starts again from zero. An external fault input removes both power-good and the converter enable at once.

Two blanking windows tell the under-voltage monitors to stay quiet while outputs ramp. The auxiliary window opens when the chip supply becomes valid. The main window opens when the AC sense qualifier reports valid input. The AC qualifier adds selectable hysteresis built from an upper-threshold flag and a lower-threshold flag. All timing counts a 100 µs strobe supplied from outside.

Top module: `pwrgood_seq`

## Requirements
- R1: The filtered request changes only after the raw request has differed from it on DEB_TICKS consecutive tick strobes. Any cycle in which the raw input matches the filtered value clears the count. After reset the filtered request is at the off level (1).
- R2: With the filtered request on (0), vdd_ok high, ac_valid high and fault low, main_en rises in the next cycle.
- R3: pgood rises only after rails_ok has stayed high for PG_TICKS tick strobes while the converter is enabled. Any cycle with rails_ok low restarts the count.
- R4: In the cycle the filtered request turns to off, pgood is low while main_en is still high.
- R5: After the filtered request turns off, main_en stays high for OFF_TICKS tick strobes and then falls.
- R6: If the filtered request returns to on during the off delay, main_en stays high and pgood qualification restarts from zero.
- R7: While fault is high, pgood and main_en are low in that same cycle. The sequencer then returns to idle and starts again from the beginning.
- R8: aux_blank goes high in the cycle after vdd_ok rises and lasts BLANK_TICKS tick strobes. vdd_ok low clears it.
- R9: main_blank goes high in the cycle after ac_valid rises and lasts BLANK_TICKS tick strobes. ac_valid low clears it.
- R10: ac_valid is registered. The hyst_sel codes are: 2'b00 follows ac_hi; 2'b10 follows ac_lo; 2'b01 and 2'b11 set on ac_hi high, clear on ac_lo low, and otherwise hold.
- R11: After reset, main_en, pgood, aux_blank, main_blank and ac_valid are all low.
- R12: vdd_ok low returns the sequencer to idle, so main_en is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 100 µs timebase strobe |
| pwr_req_n | input | 1 | Raw power-on request, low = on |
| vdd_ok | input | 1 | Chip supply valid |
| ac_hi | input | 1 | AC sense above upper threshold |
| ac_lo | input | 1 | AC sense above lower threshold |
| hyst_sel | input | 2 | AC hysteresis mode select |
| rails_ok | input | 1 | All monitored rails above under-voltage level |
| fault | input | 1 | External fault, forces shutdown |
| main_en | output | 1 | Main converter enable |
| pgood | output | 1 | Power-good |
| aux_blank | output | 1 | Auxiliary under-voltage blanking window |
| main_blank | output | 1 | Main under-voltage blanking window |
| ac_valid | output | 1 | Qualified AC input good |

## Verification
On every cycle the assertions check four things. The filtered request can only move to the raw input's level. pgood can only rise after a cycle with rails_ok high. A fault leaves main_en low in the next cycle. A power-good drop that no fault or supply loss caused leaves the converter enabled. They also check that a blanking window is open only while its start condition held, and that the hold modes keep ac_valid steady between thresholds. Only the bench scenarios can show the timing lengths: the debounce count rejecting a short glitch, the qualification restart after a rail dip, the off-delay length, the abort during the off delay, and each hysteresis mode's response. It compares these against a behavioural model on every clock.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_QUAL = 2'd1,
        SEQ_GOOD = 2'd2,
        SEQ_STOP = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        HYS_UPPER    = 2'b00,
        HYS_HOLD     = 2'b01,
        HYS_LOWER    = 2'b10,
        HYS_HOLD_ALT = 2'b11
    } hyst_mode_e;

    typedef struct packed {
        logic main_en;
        logic pgood;
    } seq_out_t;

    localparam int NUM_BLANK = 2;
    localparam int BLK_AUX   = 0;
    localparam int BLK_MAIN  = 1;

    function automatic logic hyst_next(hyst_mode_e mode, logic cur,
                                       logic up, logic lo);
        logic nxt;
        case (mode)
            HYS_UPPER: nxt = up;
            HYS_LOWER: nxt = lo;
            default: begin
                if (up)       nxt = 1'b1;
                else if (!lo) nxt = 1'b0;
                else          nxt = cur;
            end
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pwr_req_debounce.sv
module pwr_req_debounce #(
    parameter int DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw_n,
    output logic filt_n
);
    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (raw_n == filt_q) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                filt_q <= raw_n;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign filt_n = filt_q;

    AST_DEB_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> (filt_q == $past(raw_n))); // R1

endmodule

// File: rtl/ac_hyst_qual.sv
module ac_hyst_qual
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ac_hi,
    input  logic       ac_lo,
    input  logic [1:0] hyst_sel,
    output logic       ac_valid
);
    hyst_mode_e mode;
    logic       valid_q;

    assign mode = hyst_mode_e'(hyst_sel);

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= hyst_next(mode, valid_q, ac_hi, ac_lo);
    end

    assign ac_valid = valid_q;

    AST_HYST_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(hyst_sel[0]) && !$past(ac_hi) && $past(ac_lo))
        |-> (valid_q == $past(valid_q))); // R10

endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
    parameter int BLANK_TICKS = 640
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic arm,
    output logic blank
);
    localparam int CW = $clog2(BLANK_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(BLANK_TICKS);

    logic [CW-1:0] cnt_q;
    logic          arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            arm_q <= 1'b0;
        end else begin
            arm_q <= arm;
            if (!arm)                       cnt_q <= '0;
            else if (!arm_q)                cnt_q <= FULL;
            else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
    end

    assign blank = (cnt_q != '0);

    AST_BLANK_ARMED: assert property (@(posedge clk) disable iff (rst)
        blank |-> $past(arm)); // R8

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwrseq_pkg::*;
#(
    parameter int PG_TICKS  = 2500,
    parameter int OFF_TICKS = 25
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     req_on,
    input  logic     vdd_ok,
    input  logic     ac_valid,
    input  logic     rails_ok,
    input  logic     fault,
    output seq_out_t outs
);
    localparam int CNT_MAX = (PG_TICKS > OFF_TICKS) ? PG_TICKS : OFF_TICKS;
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PG_LAST  = CW'(PG_TICKS - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fault || !vdd_ok) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    cnt_d = '0;
                    if (req_on && ac_valid) state_d = SEQ_QUAL;
                end
                SEQ_QUAL: begin
                    if (!req_on) begin
                        state_d = SEQ_STOP;
                        cnt_d   = '0;
                    end else if (!rails_ok) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q == PG_LAST) begin
                            state_d = SEQ_GOOD;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                SEQ_GOOD: begin
                    cnt_d = '0;
                    if (!req_on) state_d = SEQ_STOP;
                end
                SEQ_STOP: begin
                    if (req_on) begin
                        state_d = SEQ_QUAL;
                        cnt_d   = '0;
                    end else if (tick) begin
                        if (cnt_q == OFF_LAST) begin
                            state_d = SEQ_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = SEQ_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign outs.main_en = (state_q != SEQ_IDLE) && !fault;
    assign outs.pgood   = (state_q == SEQ_GOOD) && req_on && !fault;

    AST_PG_AFTER_RAILS: assert property (@(posedge clk) disable iff (rst)
        $rose(outs.pgood) |-> $past(rails_ok)); // R3

    AST_FAULT_SHUTS: assert property (@(posedge clk) disable iff (rst)
        fault |=> !outs.main_en); // R7

    AST_OFF_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        ($fell(outs.pgood) && !fault && !$past(fault) && $past(vdd_ok))
        |-> outs.main_en); // R5

endmodule

// File: rtl/pwrgood_seq.sv
module pwrgood_seq
    import pwrseq_pkg::*;
#(
    parameter int DEB_TICKS   = 20,
    parameter int PG_TICKS    = 2500,
    parameter int OFF_TICKS   = 25,
    parameter int BLANK_TICKS = 640
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       pwr_req_n,
    input  logic       vdd_ok,
    input  logic       ac_hi,
    input  logic       ac_lo,
    input  logic [1:0] hyst_sel,
    input  logic       rails_ok,
    input  logic       fault,
    output logic       main_en,
    output logic       pgood,
    output logic       aux_blank,
    output logic       main_blank,
    output logic       ac_valid
);
    logic                 req_filt_n;
    logic                 ac_ok;
    logic [NUM_BLANK-1:0] blank_arm;
    logic [NUM_BLANK-1:0] blank_out;
    seq_out_t             seq;

    pwr_req_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .raw_n  (pwr_req_n),
        .filt_n (req_filt_n)
    );

    ac_hyst_qual u_hyst (
        .clk      (clk),
        .rst      (rst),
        .ac_hi    (ac_hi),
        .ac_lo    (ac_lo),
        .hyst_sel (hyst_sel),
        .ac_valid (ac_ok)
    );

    assign blank_arm[BLK_AUX]  = vdd_ok;
    assign blank_arm[BLK_MAIN] = ac_ok;

    for (genvar g = 0; g < NUM_BLANK; g++) begin : g_blank
        blank_timer #(.BLANK_TICKS(BLANK_TICKS)) u_blank (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .arm   (blank_arm[g]),
            .blank (blank_out[g])
        );
    end

    pwr_seq_fsm #(.PG_TICKS(PG_TICKS), .OFF_TICKS(OFF_TICKS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .req_on   (!req_filt_n),
        .vdd_ok   (vdd_ok),
        .ac_valid (ac_ok),
        .rails_ok (rails_ok),
        .fault    (fault),
        .outs     (seq)
    );

    assign main_en    = seq.main_en;
    assign pgood      = seq.pgood;
    assign aux_blank  = blank_out[BLK_AUX];
    assign main_blank = blank_out[BLK_MAIN];
    assign ac_valid   = ac_ok;

    AST_UVLO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !vdd_ok |=> !main_en); // R12

endmodule

// File: tb/tb_pwrgood_seq.sv
module tb_pwrgood_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DEB   = 4;
    localparam int PG    = 20;
    localparam int OFFT  = 5;
    localparam int BLANK = 10;
    localparam int TDIV  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic pwr_req_n = 1'b1;
    logic vdd_ok = 1'b0;
    logic ac_hi = 1'b0;
    logic ac_lo = 1'b0;
    logic [1:0] hyst_sel = 2'b01;
    logic rails_ok = 1'b0;
    logic fault = 1'b0;
    logic main_en, pgood, aux_blank, main_blank, ac_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    pwrgood_seq #(.DEB_TICKS(DEB), .PG_TICKS(PG), .OFF_TICKS(OFFT),
                  .BLANK_TICKS(BLANK)) dut (
        .clk(clk), .rst(rst), .tick(tick), .pwr_req_n(pwr_req_n),
        .vdd_ok(vdd_ok), .ac_hi(ac_hi), .ac_lo(ac_lo), .hyst_sel(hyst_sel),
        .rails_ok(rails_ok), .fault(fault), .main_en(main_en), .pgood(pgood),
        .aux_blank(aux_blank), .main_blank(main_blank), .ac_valid(ac_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc  <= cyc + 1;
        tick <= ((cyc % TDIV) == 0);
    end

    task automatic chk(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_filt, m_dcnt, m_acv, m_state, m_cnt;
    int m_aux, m_vprev, m_mb, m_aprev;

    always @(posedge clk) begin
        int ns, nc, on, nacv;
        #1;
        if (rst) begin
            m_filt = 1; m_dcnt = 0; m_acv = 0; m_state = 0; m_cnt = 0;
            m_aux = 0; m_vprev = 0; m_mb = 0; m_aprev = 0;
        end else begin
            on = (m_filt == 0);
            ns = m_state; nc = m_cnt;
            if (fault || !vdd_ok) begin ns = 0; nc = 0; end
            else if (m_state == 0) begin nc = 0; if (on && m_acv) ns = 1; end
            else if (m_state == 1) begin
                if (!on) begin ns = 3; nc = 0; end
                else if (!rails_ok) nc = 0;
                else if (tick) begin
                    if (m_cnt + 1 == PG) begin ns = 2; nc = 0; end else nc = m_cnt + 1;
                end
            end else if (m_state == 2) begin nc = 0; if (!on) ns = 3; end
            else begin
                if (on) begin ns = 1; nc = 0; end
                else if (tick) begin
                    if (m_cnt + 1 == OFFT) begin ns = 0; nc = 0; end else nc = m_cnt + 1;
                end
            end
            m_state = ns; m_cnt = nc;
            if (pwr_req_n == m_filt) m_dcnt = 0;
            else if (tick) begin
                if (m_dcnt + 1 == DEB) begin m_filt = pwr_req_n; m_dcnt = 0; end
                else m_dcnt++;
            end
            if (!vdd_ok) m_aux = 0;
            else if (!m_vprev) m_aux = BLANK;
            else if (tick && m_aux > 0) m_aux--;
            m_vprev = vdd_ok;
            if (!m_acv) m_mb = 0;
            else if (!m_aprev) m_mb = BLANK;
            else if (tick && m_mb > 0) m_mb--;
            m_aprev = m_acv;
            if (hyst_sel == 2'b00) nacv = ac_hi;
            else if (hyst_sel == 2'b10) nacv = ac_lo;
            else if (ac_hi) nacv = 1;
            else if (!ac_lo) nacv = 0;
            else nacv = m_acv;
            m_acv = nacv;
        end
        chk("R5", "main_en", main_en, (m_state != 0) && !fault);
        chk("R3", "pgood", pgood, (m_state == 2) && (m_filt == 0) && !fault);
        chk("R8", "aux_blank", aux_blank, m_aux > 0);
        chk("R9", "main_blank", main_blank, m_mb > 0);
        chk("R10", "ac_valid", ac_valid, m_acv != 0);
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pg(logic want);
        for (int i = 0; i < 400; i++) begin
            if (pgood == want) break;
            @(negedge clk);
        end
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        chk("R11", "reset main_en", main_en, 1'b0);
        chk("R11", "reset pgood", pgood, 1'b0);
        chk("R11", "reset blanks", aux_blank | main_blank, 1'b0);
        chk("R11", "reset ac_valid", ac_valid, 1'b0);

        vdd_ok = 1'b1;
        step(3);
        ac_hi = 1'b1; ac_lo = 1'b1;
        step(3);
        ac_hi = 1'b0;
        step(2);
        chk("R10", "hold keeps ac_valid", ac_valid, 1'b1);

        // R1: a glitch shorter than the debounce is ignored
        pwr_req_n = 1'b0;
        step(5);
        pwr_req_n = 1'b1;
        step(12);
        chk("R1", "glitch ignored", main_en, 1'b0);

        // R2 and R3: start-up with a rail dip
        pwr_req_n = 1'b0;
        step(2 * DEB * TDIV + 2);
        chk("R2", "main_en after request", main_en, 1'b1);
        rails_ok = 1'b1;
        step(15);
        rails_ok = 1'b0;
        step(1);
        rails_ok = 1'b1;
        step(2 * PG - 4);
        chk("R3", "pgood waits after dip", pgood, 1'b0);
        wait_pg(1'b1);
        chk("R3", "pgood asserted", pgood, 1'b1);

        // R10: mode changes
        hyst_sel = 2'b00; step(2);
        chk("R10", "mode 00 follows ac_hi", ac_valid, 1'b0);
        hyst_sel = 2'b10; step(2);
        chk("R10", "mode 10 follows ac_lo", ac_valid, 1'b1);
        hyst_sel = 2'b11; ac_hi = 1'b1; step(2);

        // R4 and R5: turn-off
        pwr_req_n = 1'b1;
        wait_pg(1'b0);
        chk("R4", "main_en held as pgood drops", main_en, 1'b1);
        step(OFFT * TDIV + 4);
        chk("R5", "main_en off after delay", main_en, 1'b0);

        // R6: abort during off delay
        pwr_req_n = 1'b0;
        wait_pg(1'b1);
        pwr_req_n = 1'b1;
        wait_pg(1'b0);
        pwr_req_n = 1'b0;
        step(DEB * TDIV + 4);
        chk("R6", "main_en kept on abort", main_en, 1'b1);
        chk("R6", "pgood requalifying", pgood, 1'b0);
        wait_pg(1'b1);
        chk("R6", "pgood after requalify", pgood, 1'b1);

        // R7: fault
        fault = 1'b1;
        #1;
        chk("R7", "fault pgood", pgood, 1'b0);
        chk("R7", "fault main_en", main_en, 1'b0);
        step(1);
        fault = 1'b0;
        step(1);
        chk("R7", "idle after fault", pgood, 1'b0);
        wait_pg(1'b1);

        // R12: supply loss
        vdd_ok = 1'b0;
        step(2);
        chk("R12", "main_en after vdd loss", main_en, 1'b0);
        chk("R8", "aux_blank cleared", aux_blank, 1'b0);
        step(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule